// File: doc/BRIEF.md
# Block Lookahead Carry Adder

This block adds two N-bit unsigned operands and a single carry input, giving an N-bit sum and a carry output. It is purely combinational. The operand width is cut into equal slices of K bits. Inside each slice a chain of full adders produces the sum bits, fed by that slice's incoming carry.

Alongside the chain, each slice reduces its per-column generate (a AND b) and propagate (a OR b) terms into one slice generate and one slice propagate. A single AND-OR step per slice then forms the carry into the next slice: generate OR (propagate AND incoming carry). The carry therefore crosses each slice through one gate pair instead of K full adders. The carry output of the block is the carry formed after the most significant slice.

The default configuration is 32 bits in eight 4-bit slices. Any width that is a whole multiple of the slice width is legal. Other widths stop elaboration.

Top module: `cla_adder`

## Requirements
- R1: For any operands and carry input, {c_o, sum_o} equals a_i + b_i + c_i computed at N+1 bits (checked for N=32, K=4).
- R2: With a_i all ones, b_i zero and c_i=1, the carry travels through every slice: sum_o is zero and c_o is 1.
- R3: A carry generated in the lowest slice and passed by upper slices whose columns only propagate reaches c_o: a_i=0xFFFFFFF8, b_i=0x00000008, c_i=0 gives sum_o=0 and c_o=1.
- R4: For alternating operands 0xAAAAAAAA and 0x55555555, sum_o is 0xFFFFFFFF with c_o=0 when c_i=0, and sum_o is 0 with c_o=1 when c_i=1.
- R5: With both operands zero, sum_o equals c_i zero-extended and c_o is 0.
- R6: Any configuration where N is a multiple of K gives the exact sum; with N=6 and K=3, all 8192 input combinations match a_i + b_i + c_i.
- R7: The carry each slice passes upward by lookahead equals the carry out of that slice's internal ripple chain. At the ports, all-ones operands with c_i=1 give sum_o all ones and c_o=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N_BITS | First operand |
| b_i | input | N_BITS | Second operand |
| c_i | input | 1 | Carry into the least significant column |
| sum_o | output | N_BITS | Sum bits |
| c_o | output | 1 | Carry out of the most significant slice |

## Verification
A wrong slice generate or propagate term shows up at once as a wrong sum in every higher slice. This happens only for operand patterns where that slice must pass or create a carry, which is why all-propagate and generate-then-propagate patterns are driven on purpose. A fault inside a ripple chain corrupts only that slice's sum bits, while c_o may stay correct. The bench therefore compares the full sum, not just the carry. Because the block has no state, every error is visible on the same evaluation that applies the operands.

// File: rtl/cla_pkg.sv
package cla_pkg;
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;
endpackage

// File: rtl/cla_column.sv
module cla_column
  import cla_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output gp_t  gp_o,
  output logic c_o
);
  always_comb begin
    gp_o.g = a_i & b_i;
    gp_o.p = a_i | b_i;
    s_o    = a_i ^ b_i ^ c_i;
    c_o    = gp_o.g | (gp_o.p & c_i);
  end
endmodule

// File: rtl/cla_carry_step.sv
module cla_carry_step
  import cla_pkg::*;
(
  input  gp_t  gp_i,
  input  logic c_i,
  output logic c_o
);
  assign c_o = gp_i.g | (gp_i.p & c_i);
endmodule

// File: rtl/cla_block.sv
module cla_block
  import cla_pkg::*;
#(
  parameter int unsigned K = 4
) (
  input  logic [K-1:0] a_i,
  input  logic [K-1:0] b_i,
  input  logic         c_i,
  output logic [K-1:0] s_o,
  output gp_t          gp_o,
  output logic         rc_o
);
  gp_t        col_gp [K];
  logic [K:0] rc;

  assign rc[0] = c_i;

  for (genvar i = 0; i < K; i++) begin : g_col
    cla_column u_col (
      .a_i  (a_i[i]),
      .b_i  (b_i[i]),
      .c_i  (rc[i]),
      .s_o  (s_o[i]),
      .gp_o (col_gp[i]),
      .c_o  (rc[i+1])
    );
  end

  assign rc_o = rc[K];

  // slice generate/propagate reduced from column terms, high column last
  always_comb begin
    gp_o.g = col_gp[0].g;
    gp_o.p = col_gp[0].p;
    for (int i = 1; i < K; i++) begin
      gp_o.g = col_gp[i].g | (col_gp[i].p & gp_o.g);
      gp_o.p = gp_o.p & col_gp[i].p;
    end
  end

  always_comb begin
    if (!$isunknown({a_i, b_i, c_i}))
      AST_BLOCK_CARRY_MATCH: assert (rc_o == (gp_o.g | (gp_o.p & c_i))); // R7
  end
endmodule

// File: rtl/cla_adder.sv
module cla_adder
  import cla_pkg::*;
#(
  parameter int unsigned N_BITS   = 32,
  parameter int unsigned BLK_BITS = 4
) (
  input  logic [N_BITS-1:0] a_i,
  input  logic [N_BITS-1:0] b_i,
  input  logic              c_i,
  output logic [N_BITS-1:0] sum_o,
  output logic              c_o
);
  localparam int unsigned NUM_BLK = N_BITS / BLK_BITS;

  if ((N_BITS % BLK_BITS) != 0 || BLK_BITS == 0) begin : g_bad_cfg
    $error("cla_adder: N_BITS must be a multiple of BLK_BITS");
  end

  gp_t              blk_gp [NUM_BLK];
  logic [NUM_BLK:0] bc;
  logic [NUM_BLK-1:0] blk_rc;

  assign bc[0] = c_i;

  for (genvar j = 0; j < NUM_BLK; j++) begin : g_blk
    cla_block #(.K(BLK_BITS)) u_blk (
      .a_i  (a_i[j*BLK_BITS +: BLK_BITS]),
      .b_i  (b_i[j*BLK_BITS +: BLK_BITS]),
      .c_i  (bc[j]),
      .s_o  (sum_o[j*BLK_BITS +: BLK_BITS]),
      .gp_o (blk_gp[j]),
      .rc_o (blk_rc[j])
    );

    cla_carry_step u_step (
      .gp_i (blk_gp[j]),
      .c_i  (bc[j]),
      .c_o  (bc[j+1])
    );
  end

  assign c_o = bc[NUM_BLK];

  always_comb begin
    if (!$isunknown({a_i, b_i, c_i})) begin
      AST_SUM_MATCH: assert ({c_o, sum_o} ==
        ({1'b0, a_i} + {1'b0, b_i} + {{N_BITS{1'b0}}, c_i})); // R1
      if (a_i == '0 && b_i == '0)
        AST_ZERO_OPS: assert (c_o == 1'b0 && sum_o == {{(N_BITS-1){1'b0}}, c_i}); // R5
      if ((a_i ^ b_i) == '1 && (a_i & b_i) == '0)
        AST_ALL_PROP: assert (c_o == c_i && sum_o == {N_BITS{~c_i}}); // R2
      AST_TOP_CARRY: assert (c_o == blk_rc[NUM_BLK-1]); // R7
    end
  end
endmodule

// File: tb/cla_adder_tb.sv
module cla_adder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [31:0] a, b, sum;
  logic        cin, cout;
  logic [5:0]  sa, sb, ssum;
  logic        scin, scout;
  int          checks = 0;
  int          errors = 0;
  bit          done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cla_adder #(.N_BITS(32), .BLK_BITS(4)) u_dut (
    .a_i(a), .b_i(b), .c_i(cin), .sum_o(sum), .c_o(cout)
  );

  cla_adder #(.N_BITS(6), .BLK_BITS(3)) u_dut_small (
    .a_i(sa), .b_i(sb), .c_i(scin), .sum_o(ssum), .c_o(scout)
  );

  task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic ci,
                       input logic [32:0] exp, input string req);
    @(posedge clk);
    a = x; b = y; cin = ci;
    @(negedge clk);
    checks++;
    if ({cout, sum} !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%0b actual=%h expected=%h", req, x, y, ci, {cout, sum}, exp);
    end
  endtask

  task automatic t_zero();
    apply(32'h0, 32'h0, 1'b0, 33'h0, "R5");
    apply(32'h0, 32'h0, 1'b1, 33'h1, "R5");
  endtask

  task automatic t_all_prop();
    apply(32'hFFFFFFFF, 32'h0, 1'b1, {1'b1, 32'h0}, "R2");
    apply(32'h0, 32'hFFFFFFFF, 1'b0, {1'b0, 32'hFFFFFFFF}, "R2");
  endtask

  task automatic t_gen_low();
    apply(32'hFFFFFFF8, 32'h00000008, 1'b0, {1'b1, 32'h0}, "R3");
    apply(32'hFFFF0F00, 32'h0000F100, 1'b0, {1'b1, 32'h00000000}, "R3");
  endtask

  task automatic t_alternate();
    apply(32'hAAAAAAAA, 32'h55555555, 1'b0, {1'b0, 32'hFFFFFFFF}, "R4");
    apply(32'hAAAAAAAA, 32'h55555555, 1'b1, {1'b1, 32'h0}, "R4");
  endtask

  task automatic t_max();
    apply(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, {1'b1, 32'hFFFFFFFF}, "R7");
    apply(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, {1'b1, 32'hFFFFFFFE}, "R7");
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      logic [31:0] x, y;
      logic        ci;
      x  = $urandom;
      y  = $urandom;
      ci = 1'($urandom);
      apply(x, y, ci, {1'b0, x} + {1'b0, y} + {32'h0, ci}, "R1");
    end
  endtask

  task automatic t_small_exhaustive();
    for (int v = 0; v < 8192; v++) begin
      logic [6:0] exp;
      @(posedge clk);
      sa = v[5:0]; sb = v[11:6]; scin = v[12];
      exp = {1'b0, v[5:0]} + {1'b0, v[11:6]} + {6'b0, v[12]};
      @(negedge clk);
      checks++;
      if ({scout, ssum} !== exp) begin
        errors++;
        $display("FAIL R6 a=%h b=%h cin=%0b actual=%h expected=%h", sa, sb, scin, {scout, ssum}, exp);
      end
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    sa = '0; sb = '0; scin = 1'b0;
    t_zero();
    t_all_prop();
    t_gen_low();
    t_alternate();
    t_max();
    t_random();
    t_small_exhaustive();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule